// File: doc/BRIEF.md
# Interrupt Source Identity and NMI Router

This block gathers grouped peripheral interrupt flags into 32 interrupt request lines. Each line has a read-only identity register that shows, bit by bit, which of its sub-sources is raising it at the moment. The identity bits are live copies of the flags. A bit drops by itself once the peripheral clears the flag, so software reads the register only to find which sub-sources to service.

Each request line is the OR of its group's live sub-source flags, registered by one clock. A control register picks one of the 32 lines and forwards it to a single non-maskable interrupt output, gated by an enable bit. The line select can be written at any time. The enable bit can only be changed after a three-byte key sequence on a separate 8-bit protection write port has opened the gate. A status output shows whether the gate is open.

Top module: `irq_ident_nmi`

## Requirements
- R1: Identity register n sits at byte address 4*n for n = 0..31. It reads back, in bits [3:0], the group's sub-source flags as sampled one clock earlier, and bits [31:4] read zero. Reset clears all identity registers.
- R2: Live sub-source bits per group: IRQ4 uses bits [1:0], IRQ5 bits [2:0], IRQ6 and IRQ7 bits [3:0], every other non-reserved group bit 0 only. Flag inputs outside a group's live bits are ignored. Several sub-sources may read 1 at once.
- R3: Reserved groups 16, 17, 20, 21, 22, 23, 24, 27, 30 and 31 always read zero and never assert their line of `irq_out`.
- R4: `irq_out[n]` is the OR of group n's live flags from the previous clock. When the flags clear, the bit returns to 0 one clock later with no software action.
- R5: Writes to identity addresses have no effect. Reads at byte addresses 0x84 and above, and at misaligned addresses, return zero.
- R6: The control register at byte address 0x80 holds the line select in bits [4:0] and the NMI enable in bit 8, and reads back the same way. The select field takes any write. Reset clears the whole register.
- R7: `nmi_out` is high exactly when the enable is 1 and the selected line of `irq_out` is 1.
- R8: The enable bit keeps its value on control writes unless `prot_open` is 1. `prot_open` rises one clock after the bytes 0x59, 0x16, 0x88 are written to the protection port in consecutive protection writes.
- R9: A protection write that is not the next expected key byte restarts the sequence. If that byte is 0x59 it counts as the first key byte. Any protection write while open closes the gate. Reset closes the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 128 | Sub-source flags, 4 per group, group n at bits [4n+3:4n] |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| prot_wr | input | 1 | Protection key write strobe |
| prot_wdata | input | 8 | Protection key byte |
| prot_open | output | 1 | Enable bit is writable |
| irq_out | output | 32 | Registered interrupt request lines |
| nmi_out | output | 1 | Non-maskable interrupt request |

## Verification
The assertions assume that the flag inputs and both write ports change only while the clock is low, and that the bus and protection strobes are ordinary single-cycle pulses with no meaning attached to their held values. The bench drives every input at the falling edge and holds it for one whole period. It fills `src_in` from a seeded random generator across all 128 bits, including dead bits and reserved groups. Random control writes change the select while the gate is open, so the enable stays fixed and each NMI expectation depends only on the select and the previous cycle's flags.

// File: rtl/irqid_pkg.sv
package irqid_pkg;

    localparam int NUM_IRQ  = 32;
    localparam int SRC_W    = 4;
    localparam int SEL_W    = $clog2(NUM_IRQ);
    localparam int NKEY     = 3;
    localparam int STEP_W   = $clog2(NKEY + 1);
    localparam int EN_BIT   = 8;
    localparam int CTRL_WORD = NUM_IRQ;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } nmi_ctrl_t;

    // Groups that are held permanently quiet.
    function automatic logic is_reserved(input int n);
        case (n)
            16, 17, 20, 21, 22, 23, 24, 27, 30, 31: return 1'b1;
            default: return (n >= NUM_IRQ);
        endcase
    endfunction

    // Which sub-source bits exist for each group.
    function automatic logic [SRC_W-1:0] live_mask(input int n);
        if (is_reserved(n)) return '0;
        case (n)
            4:       return 4'b0011;
            5:       return 4'b0111;
            6, 7:    return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction

    // Unlock key bytes in required order.
    function automatic logic [7:0] key_byte(input int i);
        case (i)
            0:       return 8'h59;
            1:       return 8'h16;
            default: return 8'h88;
        endcase
    endfunction

endpackage

// File: rtl/irqid_group.sv
module irqid_group
    import irqid_pkg::*;
#(
    parameter logic [SRC_W-1:0] LIVE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] flags,
    output logic [SRC_W-1:0] ident_q,
    output logic             irq_q
);
    logic [SRC_W-1:0] masked;
    assign masked = flags & LIVE;

    always_ff @(posedge clk) begin
        if (rst) begin
            ident_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            ident_q <= masked;
            irq_q   <= |masked;
        end
    end
endmodule

// File: rtl/irqid_unlock.sv
module irqid_unlock
    import irqid_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       open
);
    logic [STEP_W-1:0] step_q, step_d;
    logic              hit_next;

    always_comb begin
        hit_next = (int'(step_q) < NKEY) && (wdata == key_byte(int'(step_q)));
        step_d   = step_q;
        if (wr) begin
            if (hit_next)                 step_d = step_q + 1'b1;
            else if (wdata == key_byte(0)) step_d = STEP_W'(1);
            else                          step_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= '0;
        else     step_q <= step_d;
    end

    assign open = (int'(step_q) == NKEY);
endmodule

// File: rtl/irqid_nmi_route.sv
module irqid_nmi_route
    import irqid_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ctrl_wr,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic               wr_en,
    input  logic               open,
    input  logic [NUM_IRQ-1:0] irq_vec,
    output nmi_ctrl_t          ctrl_q,
    output logic               nmi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.sel <= wr_sel;
            if (open) ctrl_q.en <= wr_en;
        end
    end

    assign nmi = ctrl_q.en & irq_vec[ctrl_q.sel];
endmodule

// File: rtl/irq_ident_nmi.sv
module irq_ident_nmi
    import irqid_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_IRQ*SRC_W-1:0] src_in,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic                     prot_wr,
    input  logic [7:0]               prot_wdata,
    output logic                     prot_open,
    output logic [NUM_IRQ-1:0]       irq_out,
    output logic                     nmi_out
);
    localparam int WORD_W = ADDR_W - 2;

    logic [SRC_W-1:0] ident [NUM_IRQ];
    logic [WORD_W-1:0] word;
    logic             aligned;
    logic             ctrl_hit;
    nmi_ctrl_t        ctrl_q;
    logic             ctrl_en;

    assign word     = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign ctrl_hit = aligned && (int'(word) == CTRL_WORD);

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_grp
        irqid_group #(.LIVE(live_mask(g))) u_grp (
            .clk     (clk),
            .rst     (rst),
            .flags   (src_in[g*SRC_W +: SRC_W]),
            .ident_q (ident[g]),
            .irq_q   (irq_out[g])
        );
    end

    irqid_unlock u_unlock (
        .clk   (clk),
        .rst   (rst),
        .wr    (prot_wr),
        .wdata (prot_wdata),
        .open  (prot_open)
    );

    irqid_nmi_route u_route (
        .clk     (clk),
        .rst     (rst),
        .ctrl_wr (bus_wr && ctrl_hit),
        .wr_sel  (bus_wdata[SEL_W-1:0]),
        .wr_en   (bus_wdata[EN_BIT]),
        .open    (prot_open),
        .irq_vec (irq_out),
        .ctrl_q  (ctrl_q),
        .nmi     (nmi_out)
    );

    assign ctrl_en = ctrl_q.en;

    always_comb begin
        bus_rdata = '0;
        if (aligned && int'(word) < NUM_IRQ) begin
            bus_rdata[SRC_W-1:0] = ident[word[SEL_W-1:0]];
        end else if (ctrl_hit) begin
            bus_rdata[SEL_W-1:0] = ctrl_q.sel;
            bus_rdata[EN_BIT]    = ctrl_q.en;
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata[DATA_W-1:EN_BIT+1], bus_wdata[EN_BIT-1:SEL_W]};
endmodule

// File: rtl/irqid_checker.sv
module irqid_checker
    import irqid_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_IRQ*SRC_W-1:0] src_in,
    input logic [NUM_IRQ-1:0]       irq_out,
    input logic                     nmi_out,
    input logic                     prot_open,
    input logic                     prot_wr,
    input logic [7:0]               prot_wdata,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     ctrl_en
);
    logic [NUM_IRQ-1:0] rsv_mask;
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_rsv
        assign rsv_mask[g] = is_reserved(g);
    end

    // R3: reserved lines stay low
    a_r3_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        (irq_out & rsv_mask) == '0);

    // R4: no flags means no requests one clock later
    a_r4_idle_clears: assert property (@(posedge clk) disable iff (rst)
        (src_in == '0) |=> (irq_out == '0));

    // R7: NMI needs the enable and some active line
    a_r7_nmi_gated: assert property (@(posedge clk) disable iff (rst)
        nmi_out |-> (ctrl_en && (irq_out != '0)));

    // R8: a control write while closed keeps the enable
    a_r8_en_locked: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h80 && !prot_open) |=> $stable(ctrl_en));

    // R8: the gate opens only after the final key byte
    a_r8_open_on_key: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_open) |-> ($past(prot_wr) && $past(prot_wdata) == 8'h88));

    // R9: any protection write while open closes the gate
    a_r9_relock: assert property (@(posedge clk) disable iff (rst)
        (prot_open && prot_wr) |=> !prot_open);
endmodule

bind irq_ident_nmi irqid_checker #(.ADDR_W(ADDR_W)) u_irqid_checker (
    .clk        (clk),
    .rst        (rst),
    .src_in     (src_in),
    .irq_out    (irq_out),
    .nmi_out    (nmi_out),
    .prot_open  (prot_open),
    .prot_wr    (prot_wr),
    .prot_wdata (prot_wdata),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .ctrl_en    (ctrl_en)
);

// File: tb/irq_ident_nmi_bench.sv
`timescale 1ns/1ps
module irq_ident_nmi_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] src_in = '0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         prot_wr = 1'b0;
    logic [7:0]   prot_wdata = '0;
    logic         prot_open;
    logic [31:0]  irq_out;
    logic         nmi_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_ident_nmi u_irq_ident_nmi (
        .clk(clk), .rst(rst), .src_in(src_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prot_wr(prot_wr), .prot_wdata(prot_wdata), .prot_open(prot_open),
        .irq_out(irq_out), .nmi_out(nmi_out)
    );

    // Live bits per group, from R2 and R3.
    function automatic logic [3:0] grp_bits(int n);
        if (n inside {16, 17, 20, 21, 22, 23, 24, 27, 30, 31}) return 4'h0;
        if (n == 4) return 4'h3;
        if (n == 5) return 4'h7;
        if (n == 6 || n == 7) return 4'hF;
        return 4'h1;
    endfunction

    function automatic logic [31:0] want_ident(logic [127:0] s, int n);
        return {28'h0, s[n*4 +: 4] & grp_bits(n)};
    endfunction

    function automatic logic [31:0] want_irq(logic [127:0] s);
        logic [31:0] v;
        for (int n = 0; n < 32; n++) v[n] = |(s[n*4 +: 4] & grp_bits(n));
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_at(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic key(logic [7:0] b);
        @(negedge clk);
        prot_wr = 1'b1; prot_wdata = b;
        @(negedge clk);
        prot_wr = 1'b0;
    endtask

    task automatic set_src(logic [127:0] s);
        @(negedge clk);
        src_in = s;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0]  d;
        logic [127:0] s;
        logic [127:0] s_prev;
        logic [4:0]   sel;
        void'($urandom(32'h1D5EED));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 R6 R8: reset values
        check("R4 reset irq_out", irq_out, 32'h0);
        check("R7 reset nmi_out", {31'h0, nmi_out}, 32'h0);
        check("R8 reset prot_open", {31'h0, prot_open}, 32'h0);
        read_at(8'h80, d); check("R6 reset ctrl", d, 32'h0);
        read_at(8'h14, d); check("R1 reset ident", d, 32'h0);

        // R1 R2: several sub-sources at once, dead bits ignored
        s = '0;
        s[0*4 +: 4] = 4'b0011;
        s[5*4 +: 4] = 4'b1111;
        s[6*4 +: 4] = 4'b1001;
        s[4*4 +: 4] = 4'b0110;
        set_src(s);
        read_at(8'h00, d); check("R2 ident0 dead bit", d, 32'h1);
        read_at(8'h14, d); check("R2 ident5 multi", d, 32'h7);
        read_at(8'h18, d); check("R2 ident6 multi", d, 32'h9);
        read_at(8'h10, d); check("R2 ident4 masked", d, 32'h2);
        check("R4 irq lines", irq_out, 32'h71);

        // R3: everything raised, reserved stay quiet
        set_src({128{1'b1}});
        read_at(8'h40, d); check("R3 ident16", d, 32'h0);
        read_at(8'h7C, d); check("R3 ident31", d, 32'h0);
        check("R3 irq_out all", irq_out, want_irq({128{1'b1}}));

        // R4: automatic clear
        set_src(s);
        set_src('0);
        read_at(8'h14, d); check("R4 ident auto clear", d, 32'h0);
        check("R4 irq auto clear", irq_out, 32'h0);

        // R5: write to identity ignored
        set_src(s);
        bus_write(8'h18, 32'h0);
        read_at(8'h18, d); check("R5 ident write ignored", d, 32'h9);
        bus_write(8'h14, 32'hFFFF_FFFF);
        read_at(8'h14, d); check("R5 ident write ignored 2", d, 32'h7);

        // R6 R8: select takes the write, enable does not while closed
        bus_write(8'h80, 32'h0000_0106);
        read_at(8'h80, d); check("R8 en locked, R6 sel written", d, 32'h6);
        check("R7 nmi off when disabled", {31'h0, nmi_out}, 32'h0);

        // R8: key sequence opens the gate
        key(8'h59); key(8'h16); key(8'h88);
        check("R8 open after keys", {31'h0, prot_open}, 32'h1);
        bus_write(8'h80, 32'h0000_0106);
        read_at(8'h80, d); check("R8 en written when open", d, 32'h106);
        check("R7 nmi routes irq6", {31'h0, nmi_out}, 32'h1);

        // R9: write while open relocks; enable then held
        key(8'h00);
        check("R9 relock", {31'h0, prot_open}, 32'h0);
        bus_write(8'h80, 32'h0000_0003);
        read_at(8'h80, d); check("R9 en held after relock", d, 32'h103);
        check("R7 nmi follows sel 3 idle", {31'h0, nmi_out}, 32'h0);

        // R9: broken sequence restarts
        key(8'h59); key(8'h00); key(8'h16); key(8'h88);
        check("R9 broken order stays closed", {31'h0, prot_open}, 32'h0);
        key(8'h59); key(8'h59); key(8'h16); key(8'h88);
        check("R9 repeated first key counts", {31'h0, prot_open}, 32'h1);
        key(8'h59);
        check("R9 first key while open closes", {31'h0, prot_open}, 32'h0);
        key(8'h16); key(8'h88);
        check("R9 first key restarts sequence", {31'h0, prot_open}, 32'h1);

        // R5: unmapped and misaligned reads
        read_at(8'h84, d); check("R5 unmapped 0x84", d, 32'h0);
        read_at(8'hFC, d); check("R5 unmapped 0xFC", d, 32'h0);
        read_at(8'h15, d); check("R5 misaligned", d, 32'h0);

        // R1 R2 R4 R7: random flags and random select, enable fixed at 1
        bus_write(8'h80, 32'h0000_0100);
        sel = 5'd0;
        s_prev = '0;
        @(negedge clk);
        src_in = '0;
        for (int it = 0; it < 400; it++) begin
            int n;
            @(negedge clk);
            bus_wr = 1'b0;
            n = int'($urandom_range(31, 0));
            read_at(8'(n * 4), d);
            check("R1 random ident", d, want_ident(s_prev, n));
            check("R4 random irq", irq_out, want_irq(s_prev));
            check("R7 random nmi", {31'h0, nmi_out}, {31'h0, want_irq(s_prev)[sel]});
            s = {$urandom, $urandom, $urandom, $urandom};
            if ((it % 3) == 0) s = s & {$urandom, $urandom, $urandom, $urandom};
            src_in = s;
            s_prev = s;
            if ((it % 5) == 0) begin
                sel = 5'($urandom_range(31, 0));
                bus_wr = 1'b1; bus_addr = 8'h80; bus_wdata = {23'h0, 1'b1, 3'h0, sel};
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule